// File: doc/BRIEF.md
# Bridge Uncorrectable Error Reporting Unit

This block sits beside the secondary-bus side of a PCIe-to-PCI/PCI-X bridge and turns error events into architectural state and actions. Each error source raises a one-cycle strobe and presents the header of the failing transaction with it. The unit sets sticky status bits and captures the header of the first unmasked error into a four-word log with a pointer to that error. It also decides whether an error message must be sent upstream, and with which severity. In the same cycle it tells the transaction path what to do with the failing transaction. A master-abort on a forwarded non-posted request is answered with an Unsupported Request completion. A master-abort on a split completion makes the whole transaction be dropped.

Software provides a mask bit and a severity bit for each error, a system-error enable, and separate fatal and non-fatal reporting enables. It clears status by writing ones on the clear inputs. The message request waits at the upstream port under a valid/ready handshake. Error index 0 is the master-abort on a non-posted request and index 1 is the master-abort on a split completion. The other indices are further uncorrectable errors that take no transaction action. Priority for logging goes by index, lowest first.

Top module: `bridge_ue_report`

## Requirements
- R1: An event on error 0 gives a one-cycle `cpl_ur_o` pulse one cycle after the strobe, whatever the mask and enables are.
- R2: An event on error 1 gives a one-cycle `discard_o` pulse one cycle after the strobe and no `cpl_ur_o`. It also sets both the split-completion-discarded bit (`sc_disc_o`) and the master-abort-on-split-completion bit (`ma_sc_o`).
- R3: `ue_status_o[i]` is set by every event on error i, masked or not. It stays set until `clr_ue_i[i]` is written. An event in the same cycle as its clear wins.
- R4: The header of an event is captured into `hdr_log_o` only when that error is unmasked and the pointer is not valid. The log does not change while the pointer is valid, and masked events are never logged.
- R5: When several unmasked events arrive in one cycle and the pointer is free, the lowest-numbered error is logged and `err_ptr_o` takes its index.
- R6: A write to `clr_ue_i` at the bit that `err_ptr_o` names clears `err_ptr_vld_o` on the next cycle, and a later unmasked error is then logged.
- R7: An error message is generated only for an unmasked event, and only when `serr_en_i` is set or the reporting enable matching its severity (`fatal_rep_en_i` or `nonfatal_rep_en_i`) is set.
- R8: `msg_fatal_o` is 1 when any generating event in the cycle has its `sev_i` bit set (1 = fatal). A fatal message merged into a pending one upgrades it to fatal.
- R9: `msg_valid_o` rises one cycle after a generating event and stays high until `msg_ready_i` is sampled high. A new generating event while the request is pending and not accepted merges into that one request.
- R10: `sig_serr_o` is set only in a cycle in which a message is generated while `serr_en_i` is high.
- R11: Every event sets `fatal_det_o` or `nonfatal_det_o` according to its severity, regardless of mask and enables.
- R12: After reset every output is 0.
- R13: `clr_misc_i` clears its sticky bits by writing 1: bit 0 `sig_serr_o`, bit 1 `fatal_det_o`, bit 2 `nonfatal_det_o`, bit 3 `sc_disc_o`, bit 4 `ma_sc_o`. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_ERR | One-cycle error event strobes, one per error |
| evt_hdr_i | input | NUM_ERR*HDR_WORDS*WORD_W | Header of the failing transaction for each error, error i at slice i |
| mask_i | input | NUM_ERR | Per-error mask, 1 = masked |
| sev_i | input | NUM_ERR | Per-error severity, 1 = fatal |
| serr_en_i | input | 1 | System-error enable |
| fatal_rep_en_i | input | 1 | Fatal reporting enable |
| nonfatal_rep_en_i | input | 1 | Non-fatal reporting enable |
| clr_ue_i | input | NUM_ERR | Write-one-to-clear strobes for the per-error status |
| clr_misc_i | input | 5 | Write-one-to-clear strobes for the summary status bits |
| msg_ready_i | input | 1 | Upstream port accepts the message request |
| ue_status_o | output | NUM_ERR | Sticky per-error status |
| fatal_det_o | output | 1 | Fatal error detected |
| nonfatal_det_o | output | 1 | Non-fatal error detected |
| sig_serr_o | output | 1 | System error signalled |
| sc_disc_o | output | 1 | Split completion discarded |
| ma_sc_o | output | 1 | Master-abort on split completion |
| err_ptr_o | output | PTR_W | Index of the logged error |
| err_ptr_vld_o | output | 1 | Pointer and log valid |
| hdr_log_o | output | HDR_WORDS*WORD_W | Captured header |
| msg_valid_o | output | 1 | Error message request pending |
| msg_fatal_o | output | 1 | Severity of the pending message, 1 = fatal |
| cpl_ur_o | output | 1 | Return Unsupported Request completion |
| discard_o | output | 1 | Discard the split completion |

## Verification
Every result of this unit is registered once. Status bits, pointer, log, the action pulses and the rise of the message request are all due on the first clock edge after the strobe, with no further delay anywhere. The message request then holds for as many cycles as `msg_ready_i` stays low. The driver applies one stimulus per cycle on the falling edge. From its own model it computes the complete output state due after the next rising edge and queues it tagged with that cycle number. The monitor compares on the falling edge of exactly that cycle, so held messages, merges and same-cycle set/clear cases are checked cycle by cycle.

// File: rtl/bue_pkg.sv
package bue_pkg;

  // bit positions inside the summary clear vector
  localparam int MISC_W     = 5;
  localparam int MISC_SERR  = 0;
  localparam int MISC_FDET  = 1;
  localparam int MISC_NFDET = 2;
  localparam int MISC_SCDIS = 3;
  localparam int MISC_MASC  = 4;

  // a message may go out if system-error reporting is on or the
  // enable for this severity is on
  function automatic logic report_enabled(input logic is_fatal,
                                          input logic serr_en,
                                          input logic fatal_en,
                                          input logic nonfatal_en);
    return serr_en | (is_fatal ? fatal_en : nonfatal_en);
  endfunction

  // write-one-to-clear sticky bit, a set in the same cycle wins
  function automatic logic sticky_next(input logic cur,
                                       input logic set,
                                       input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // severity of a request after a new message arrives; the old
  // severity survives only when the old request was not taken
  function automatic logic merged_severity(input logic pend,
                                           input logic taken,
                                           input logic old_fatal,
                                           input logic new_fatal);
    return new_fatal | (pend & ~taken & old_fatal);
  endfunction

endpackage

// File: rtl/bue_status.sv
module bue_status
  import bue_pkg::*;
#(
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] evt_i,
  input  logic [NUM_ERR-1:0] sev_i,
  input  logic [NUM_ERR-1:0] clr_ue_i,
  input  logic [MISC_W-1:0]  clr_misc_i,
  input  logic               split_evt_i,
  input  logic               msg_gen_i,
  input  logic               serr_en_i,
  output logic [NUM_ERR-1:0] ue_status_o,
  output logic [MISC_W-1:0]  misc_o
);

  logic [NUM_ERR-1:0] ue_q;
  logic [MISC_W-1:0]  misc_q;
  logic [MISC_W-1:0]  misc_set;
  logic               any_fatal;
  logic               any_nonfatal;

  always_comb begin
    any_fatal    = |(evt_i & sev_i);
    any_nonfatal = |(evt_i & ~sev_i);
    misc_set             = '0;
    misc_set[MISC_SERR]  = msg_gen_i & serr_en_i;
    misc_set[MISC_FDET]  = any_fatal;
    misc_set[MISC_NFDET] = any_nonfatal;
    misc_set[MISC_SCDIS] = split_evt_i;
    misc_set[MISC_MASC]  = split_evt_i;
  end

  for (genvar e = 0; e < NUM_ERR; e++) begin : g_ue
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ue_q[e] <= 1'b0;
      else        ue_q[e] <= sticky_next(ue_q[e], evt_i[e], clr_ue_i[e]);
    end
  end

  for (genvar k = 0; k < MISC_W; k++) begin : g_misc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) misc_q[k] <= 1'b0;
      else        misc_q[k] <= sticky_next(misc_q[k], misc_set[k], clr_misc_i[k]);
    end
  end

  assign ue_status_o = ue_q;
  assign misc_o      = misc_q;

  AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ue_q & $past(ue_q & ~clr_ue_i)) == $past(ue_q & ~clr_ue_i))); // R3
  AST_FDET_ON_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & sev_i)) |=> misc_q[MISC_FDET]); // R11
  AST_NFDET_ON_NONFATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ~sev_i)) |=> misc_q[MISC_NFDET]); // R11

endmodule

// File: rtl/bue_hdr_log.sv
module bue_hdr_log #(
  parameter int NUM_ERR = 4,
  parameter int HDR_W   = 128,
  parameter int PTR_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ERR-1:0]       unmasked_i,
  input  logic [NUM_ERR*HDR_W-1:0] hdr_flat_i,
  input  logic [NUM_ERR-1:0]       clr_ue_i,
  output logic [PTR_W-1:0]         ptr_o,
  output logic                     ptr_vld_o,
  output logic [HDR_W-1:0]         log_o
);

  logic [PTR_W-1:0] ptr_q;
  logic             vld_q;
  logic [HDR_W-1:0] log_q;
  logic [PTR_W-1:0] pick_idx;
  logic             log_now;
  logic             clear_hit;

  // lowest index wins: walk from the top so the last hit is the lowest
  always_comb begin
    pick_idx = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (unmasked_i[i]) pick_idx = PTR_W'(i);
    end
    log_now   = ~vld_q & (|unmasked_i);
    clear_hit = vld_q & clr_ue_i[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
      log_q <= '0;
    end else if (log_now) begin
      ptr_q <= pick_idx;
      vld_q <= 1'b1;
      log_q <= hdr_flat_i[pick_idx*HDR_W +: HDR_W];
    end else if (clear_hit) begin
      vld_q <= 1'b0;
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_vld_o = vld_q;
  assign log_o     = log_q;

  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q)) |-> ($stable(log_q) && $stable(ptr_q))); // R4
  AST_PTR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && clr_ue_i[ptr_q]) |=> !vld_q); // R6
  AST_LOG_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && (|unmasked_i)) |=> vld_q); // R4

endmodule

// File: rtl/bue_msg.sv
module bue_msg
  import bue_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gen_i,
  input  logic gen_fatal_i,
  input  logic ready_i,
  output logic valid_o,
  output logic fatal_o
);

  logic valid_q;
  logic fatal_q;
  logic taken;

  assign taken = valid_q & ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fatal_q <= 1'b0;
    end else if (gen_i) begin
      valid_q <= 1'b1;
      fatal_q <= merged_severity(valid_q, taken, fatal_q, gen_fatal_i);
    end else if (taken) begin
      valid_q <= 1'b0;
      fatal_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign fatal_o = fatal_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> valid_q); // R9
  AST_MSG_SEV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && fatal_q && !ready_i) |=> fatal_q); // R8
  AST_MSG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_i |=> valid_q); // R9

endmodule

// File: rtl/bridge_ue_report.sv
module bridge_ue_report
  import bue_pkg::*;
#(
  parameter int NUM_ERR   = 4,
  parameter int HDR_WORDS = 4,
  parameter int WORD_W    = 32,
  parameter logic [NUM_ERR-1:0] UR_MAP   = NUM_ERR'(1),
  parameter logic [NUM_ERR-1:0] DISC_MAP = NUM_ERR'(2),
  localparam int HDR_W = HDR_WORDS * WORD_W,
  localparam int PTR_W = (NUM_ERR > 1) ? $clog2(NUM_ERR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ERR-1:0]       evt_i,
  input  logic [NUM_ERR*HDR_W-1:0] evt_hdr_i,
  input  logic [NUM_ERR-1:0]       mask_i,
  input  logic [NUM_ERR-1:0]       sev_i,
  input  logic                     serr_en_i,
  input  logic                     fatal_rep_en_i,
  input  logic                     nonfatal_rep_en_i,
  input  logic [NUM_ERR-1:0]       clr_ue_i,
  input  logic [MISC_W-1:0]        clr_misc_i,
  input  logic                     msg_ready_i,
  output logic [NUM_ERR-1:0]       ue_status_o,
  output logic                     fatal_det_o,
  output logic                     nonfatal_det_o,
  output logic                     sig_serr_o,
  output logic                     sc_disc_o,
  output logic                     ma_sc_o,
  output logic [PTR_W-1:0]         err_ptr_o,
  output logic                     err_ptr_vld_o,
  output logic [HDR_W-1:0]         hdr_log_o,
  output logic                     msg_valid_o,
  output logic                     msg_fatal_o,
  output logic                     cpl_ur_o,
  output logic                     discard_o
);

  // named internal events, visible to the assertions
  logic [NUM_ERR-1:0] evt_unmasked;
  logic               gen_fatal;
  logic               gen_nonfatal;
  logic               msg_gen;
  logic               ur_evt;
  logic               split_evt;
  logic               ur_q;
  logic               disc_q;
  logic [MISC_W-1:0]  misc;

  always_comb begin
    evt_unmasked = evt_i & ~mask_i;
    gen_fatal    = (|(evt_unmasked & sev_i)) &
                   report_enabled(1'b1, serr_en_i, fatal_rep_en_i, nonfatal_rep_en_i);
    gen_nonfatal = (|(evt_unmasked & ~sev_i)) &
                   report_enabled(1'b0, serr_en_i, fatal_rep_en_i, nonfatal_rep_en_i);
    msg_gen      = gen_fatal | gen_nonfatal;
    ur_evt       = |(evt_i & UR_MAP);
    split_evt    = |(evt_i & DISC_MAP);
  end

  // transaction actions, one cycle after the event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ur_q   <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      ur_q   <= ur_evt;
      disc_q <= split_evt;
    end
  end

  bue_status #(
    .NUM_ERR (NUM_ERR)
  ) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .sev_i       (sev_i),
    .clr_ue_i    (clr_ue_i),
    .clr_misc_i  (clr_misc_i),
    .split_evt_i (split_evt),
    .msg_gen_i   (msg_gen),
    .serr_en_i   (serr_en_i),
    .ue_status_o (ue_status_o),
    .misc_o      (misc)
  );

  bue_hdr_log #(
    .NUM_ERR (NUM_ERR),
    .HDR_W   (HDR_W),
    .PTR_W   (PTR_W)
  ) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .unmasked_i (evt_unmasked),
    .hdr_flat_i (evt_hdr_i),
    .clr_ue_i   (clr_ue_i),
    .ptr_o      (err_ptr_o),
    .ptr_vld_o  (err_ptr_vld_o),
    .log_o      (hdr_log_o)
  );

  bue_msg u_msg (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_i       (msg_gen),
    .gen_fatal_i (gen_fatal),
    .ready_i     (msg_ready_i),
    .valid_o     (msg_valid_o),
    .fatal_o     (msg_fatal_o)
  );

  assign sig_serr_o     = misc[MISC_SERR];
  assign fatal_det_o    = misc[MISC_FDET];
  assign nonfatal_det_o = misc[MISC_NFDET];
  assign sc_disc_o      = misc[MISC_SCDIS];
  assign ma_sc_o        = misc[MISC_MASC];
  assign cpl_ur_o       = ur_q;
  assign discard_o      = disc_q;

  AST_UR_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ur_o |-> $past(|(evt_i & UR_MAP))); // R1
  AST_DISC_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> (sc_disc_o && ma_sc_o)); // R2
  AST_PTR_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    err_ptr_vld_o |-> ue_status_o[err_ptr_o]); // R6
  AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_serr_o) |-> $past(serr_en_i)); // R10
  AST_MASKED_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid_o && ((evt_i & ~mask_i) == '0)) |=> !msg_valid_o); // R7

endmodule

// File: tb/bridge_ue_report_bench.sv
module bridge_ue_report_bench;

  localparam int N  = 4;
  localparam int HW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    evt, mask, sev, clr_ue;
  logic [N*HW-1:0] hdr;
  logic            serr_en, fen, nen, rdy;
  logic [4:0]      clr_misc;
  logic [N-1:0]    ue;
  logic            fd, nfd, ss, sd, ms, pv, mv, mf, ur, dc;
  logic [1:0]      ptr;
  logic [HW-1:0]   log_w;

  bridge_ue_report u_bridge_ue_report (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_hdr_i(hdr), .mask_i(mask),
    .sev_i(sev), .serr_en_i(serr_en), .fatal_rep_en_i(fen),
    .nonfatal_rep_en_i(nen), .clr_ue_i(clr_ue), .clr_misc_i(clr_misc),
    .msg_ready_i(rdy), .ue_status_o(ue), .fatal_det_o(fd),
    .nonfatal_det_o(nfd), .sig_serr_o(ss), .sc_disc_o(sd), .ma_sc_o(ms),
    .err_ptr_o(ptr), .err_ptr_vld_o(pv), .hdr_log_o(log_w),
    .msg_valid_o(mv), .msg_fatal_o(mf), .cpl_ur_o(ur), .discard_o(dc)
  );

  typedef struct {
    int          due;
    logic [N-1:0] ue;
    logic [4:0]  misc;
    logic [1:0]  ptr;
    logic        vld;
    logic [HW-1:0] log;
    logic        mv, mf, ur, dc;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference state
  logic [N-1:0]  m_ue = '0;
  logic [4:0]    m_misc = '0;
  logic [1:0]    m_ptr = '0;
  logic          m_vld = 1'b0;
  logic [HW-1:0] m_log = '0;
  logic          m_mv = 1'b0, m_mf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] mk_hdr(input int c, input int i);
    return {32'hC0DE_0000 + 32'(i), 32'(c), 32'h5A5A_0000 + 32'(i), 32'(c * 7 + i)};
  endfunction

  task automatic step(input logic [N-1:0] e, input logic [N-1:0] mk, input logic [N-1:0] sv,
                      input logic [N-1:0] cu, input logic [4:0] cm, input logic se,
                      input logic fe, input logic ne, input logic r);
    exp_t x;
    logic [N-1:0] um;
    logic gf, gn, g;
    int   pick;
    @(negedge clk);
    evt = e; mask = mk; sev = sv; clr_ue = cu; clr_misc = cm;
    serr_en = se; fen = fe; nen = ne; rdy = r;
    for (int i = 0; i < N; i++) hdr[i*HW +: HW] = mk_hdr(cyc, i);
    // model
    um = e & ~mk;
    gf = ((um & sv) != 0) && (se || fe);
    gn = ((um & ~sv) != 0) && (se || ne);
    g  = gf || gn;
    pick = -1;
    for (int i = 0; i < N; i++) if (um[i] && pick < 0) pick = i;
    if (!m_vld && pick >= 0) begin
      m_vld = 1'b1; m_ptr = 2'(pick); m_log = mk_hdr(cyc, pick);
    end else if (m_vld && cu[m_ptr]) begin
      m_vld = 1'b0;
    end
    m_ue = (m_ue & ~cu) | e;
    m_misc[0] = (m_misc[0] & ~cm[0]) | (g & se);
    m_misc[1] = (m_misc[1] & ~cm[1]) | ((e & sv) != 0);
    m_misc[2] = (m_misc[2] & ~cm[2]) | ((e & ~sv) != 0);
    m_misc[3] = (m_misc[3] & ~cm[3]) | e[1];
    m_misc[4] = (m_misc[4] & ~cm[4]) | e[1];
    if (g) begin
      m_mf = gf | (m_mv & ~r & m_mf);
      m_mv = 1'b1;
    end else if (m_mv && r) begin
      m_mv = 1'b0; m_mf = 1'b0;
    end
    x.due = cyc + 1; x.ue = m_ue; x.misc = m_misc; x.ptr = m_ptr; x.vld = m_vld;
    x.log = m_log; x.mv = m_mv; x.mf = m_mf; x.ur = e[0]; x.dc = e[1];
    q.push_back(x);
  endtask

  // monitor: compares the expectation due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t x;
      x = q.pop_front();
      chk("R3 ue_status", HW'(ue), HW'(x.ue));
      chk("R11 fatal_det", HW'(fd), HW'(x.misc[1]));
      chk("R11 nonfatal_det", HW'(nfd), HW'(x.misc[2]));
      chk("R10 sig_serr", HW'(ss), HW'(x.misc[0]));
      chk("R2 R13 sc_disc", HW'(sd), HW'(x.misc[3]));
      chk("R2 R13 ma_sc", HW'(ms), HW'(x.misc[4]));
      chk("R6 ptr_vld", HW'(pv), HW'(x.vld));
      if (x.vld) begin
        chk("R5 err_ptr", HW'(ptr), HW'(x.ptr));
        chk("R4 hdr_log", log_w, x.log);
      end
      chk("R7 R9 msg_valid", HW'(mv), HW'(x.mv));
      chk("R8 msg_fatal", HW'(mf), HW'(x.mf));
      chk("R1 cpl_ur", HW'(ur), HW'(x.ur));
      chk("R2 discard", HW'(dc), HW'(x.dc));
    end
  end

  initial begin
    evt = '0; mask = '0; sev = '0; clr_ue = '0; clr_misc = '0; hdr = '0;
    serr_en = 0; fen = 0; nen = 0; rdy = 0;
    repeat (3) @(negedge clk);
    // R12: state held in reset
    chk("R12 reset ue", HW'(ue), '0);
    chk("R12 reset msg", HW'({mv, mf, ur, dc, pv}), '0);
    chk("R12 reset summary", HW'({fd, nfd, ss, sd, ms}), '0);
    rst_n = 1'b1;
    step('0, '0, '0, '0, '0, 0, 0, 0, 0);                  // R12 idle after reset
    step(4'b0001, '0, '0, '0, '0, 0, 0, 1, 0);             // R1 R4 R7 nonfatal message
    step('0, '0, '0, '0, '0, 0, 0, 0, 0);                  // R9 hold
    step(4'b0010, '0, 4'b0010, '0, '0, 0, 0, 0, 0);        // R2 R11 no enable, log frozen
    step('0, '0, '0, '0, '0, 0, 0, 0, 1);                  // R9 accept
    step('0, '0, '0, 4'b0010, '0, 0, 0, 0, 0);             // R3 clear non-pointer bit
    step('0, '0, '0, 4'b0001, '0, 0, 0, 0, 0);             // R6 pointer released
    step(4'b1110, 4'b0100, 4'b0010, '0, '0, 1, 0, 0, 0);   // R5 R8 R10 priority
    step('0, '0, '0, '0, '0, 0, 0, 0, 1);                  // R9 accept
    step(4'b0001, 4'b1111, '0, 4'b1111, '0, 1, 1, 1, 0);   // R3 set beats clear, R7 masked
    step(4'b1000, 4'b1111, '0, '0, '0, 1, 1, 1, 0);        // R4 masked not logged
    step(4'b0100, '0, '0, '0, '0, 0, 0, 1, 0);             // R4 log again, nonfatal pending
    step(4'b1000, '0, 4'b1000, '0, '0, 0, 1, 0, 0);        // R8 merge upgrades to fatal
    step('0, '0, '0, '0, '0, 0, 0, 0, 1);                  // R9 accept
    step('0, '0, '0, '0, 5'b11111, 0, 0, 0, 0);            // R13 clear summary bits
    step(4'b0010, 4'b0010, '0, '0, 5'b11000, 0, 0, 0, 0);  // R13 set beats clear
    step('0, '0, '0, '0, '0, 0, 0, 0, 1);
    step('0, '0, '0, '0, '0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule